// File: doc/BRIEF.md
# Transmit Frame Statistics Counters

This block watches the end of every transmitted frame and sorts it into one of three error classes: too long, too short with a good checksum, or too short with a bad checksum. It keeps a 12-bit wrapping counter for each class. Each completed frame arrives as a single-cycle strobe together with its byte length and four qualifiers: VLAN tag present, checksum (FCS) good, FCS checking enabled, and frame aborted as a jumbo.

A counter that wraps from its top value to zero records the event in its own sticky carry bit. A mask register has one bit per carry. A carry whose mask bit is clear raises a single overflow status flag. That flag is visible on a pin and in the register space. It stays set until software writes one to clear it.

Software reaches the counters, carries, mask and status flag through a flat register port. Reads return data in the same cycle. Writes take effect at the clock edge.

Top module: `txstat_top`

## Requirements
- R1: A frame with a good FCS and a length above 1518 bytes (untagged) or above 1532 bytes (VLAN-tagged) increments the oversize counter, which is at address 0.
- R2: A frame with a good FCS and a length below 64 bytes increments the undersize counter, which is at address 1.
- R3: A frame with a bad FCS and a length below 64 bytes increments the fragment counter, which is at address 2. The undersize counter is left unchanged.
- R4: An aborted jumbo frame sent while FCS checking is off counts as a zero-length frame. It increments the undersize counter whatever its length and FCS flag.
- R5: A strobe changes at most one counter. Two kinds of frame change no counter: a frame from 64 bytes up to its oversize limit inclusive, and an over-limit frame with a bad FCS.
- R6: After synchronous reset, all counters, carries, mask bits and the status flag read as zero. Counters are 12 bits wide and can be read and written. A read returns data in the same cycle.
- R7: An increment from 0xFFF wraps the counter to 0x000 and sets its carry bit on the same clock edge. The carry register is at address 3: bit 0 is oversize, bit 1 is undersize, bit 2 is fragment. Carry bits are sticky.
- R8: A write to a counter address loads the written value and clears that counter's carry bit. The write wins over an increment in the same cycle.
- R9: The mask register is at address 4, with bit positions as in R7. One clock edge after any carry bit is set while its mask bit is clear, the status flag sets. A set mask bit keeps its carry from raising the flag but does not stop the carry from being recorded.
- R10: The status flag appears on `ovf_irq` and at address 5, bit 0. It stays set until software writes 1 to bit 0 of address 5. If an unmasked carry is still set, the flag sets again one edge after it was cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fd_valid | input | 1 | Frame-done strobe, one cycle per frame |
| fd_len | input | 16 | Byte length of the completed frame |
| fd_vlan | input | 1 | Frame carries a VLAN tag |
| fd_fcs_ok | input | 1 | Frame FCS is correct |
| fd_fcs_chk | input | 1 | FCS checking is enabled |
| fd_jumbo_abort | input | 1 | Frame was aborted as a jumbo |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 12 | Register write data |
| reg_rdata | output | 12 | Register read data (same cycle) |
| ovf_irq | output | 1 | Statistics overflow status flag |

## Verification
Counter values and carry bits settle on the same edge that samples the frame strobe or the register write. The bench therefore reads them half a cycle after that edge. The status flag is one register further on, so it is due one edge after a carry sets, a mask bit clears or a clear write lands. The bench checks the flag both before and after that edge, so an early flag or a late flag is reported. Register reads are combinational. Each read is sampled a short delay after the address changes, away from any clock edge.

// File: rtl/txstat_pkg.sv
package txstat_pkg;

    localparam int CNT_W        = 12;
    localparam int LEN_W        = 16;
    localparam int NUM_CNT      = 3;
    localparam int ADDR_W       = 3;
    localparam int MIN_LEN      = 64;
    localparam int MAX_LEN      = 1518;
    localparam int MAX_LEN_VLAN = 1532;

    // Counter indices; the carry and mask bit positions follow them.
    localparam int IDX_OVR = 0;
    localparam int IDX_UND = 1;
    localparam int IDX_FRG = 2;

    typedef enum logic [1:0] {
        CLS_NONE      = 2'd0,
        CLS_OVERSIZE  = 2'd1,
        CLS_UNDERSIZE = 2'd2,
        CLS_FRAGMENT  = 2'd3
    } frame_cls_e;

    typedef enum logic [ADDR_W-1:0] {
        A_OVR   = 3'd0,
        A_UND   = 3'd1,
        A_FRG   = 3'd2,
        A_CARRY = 3'd3,
        A_MASK  = 3'd4,
        A_STAT  = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             vlan;
        logic             fcs_ok;
        logic             fcs_chk;
        logic             jumbo_abort;
    } frame_info_t;

    localparam logic [LEN_W-1:0] LIM_MIN  = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] LIM_MAX  = LEN_W'(MAX_LEN);
    localparam logic [LEN_W-1:0] LIM_VMAX = LEN_W'(MAX_LEN_VLAN);

    // Sort one completed frame into its statistics class.
    function automatic frame_cls_e classify(frame_info_t f);
        logic [LEN_W-1:0] eff_len;
        logic [LEN_W-1:0] limit;
        frame_cls_e       cls;
        // An aborted jumbo with checking off is reported as zero length.
        if (f.jumbo_abort && !f.fcs_chk) begin
            cls = CLS_UNDERSIZE;
        end else begin
            eff_len = f.len;
            limit   = f.vlan ? LIM_VMAX : LIM_MAX;
            if (eff_len < LIM_MIN)
                cls = f.fcs_ok ? CLS_UNDERSIZE : CLS_FRAGMENT;
            else if (eff_len > limit && f.fcs_ok)
                cls = CLS_OVERSIZE;
            else
                cls = CLS_NONE;
        end
        return cls;
    endfunction

endpackage

// File: rtl/txstat_classify.sv
module txstat_classify
    import txstat_pkg::*;
#(
    parameter int N = NUM_CNT
) (
    input  logic        frame_valid,
    input  frame_info_t info,
    output logic [N-1:0] inc
);
    frame_cls_e cls;

    always_comb begin
        cls = classify(info);
        inc = '0;
        if (frame_valid) begin
            case (cls)
                CLS_OVERSIZE:  inc[IDX_OVR] = 1'b1;
                CLS_UNDERSIZE: inc[IDX_UND] = 1'b1;
                CLS_FRAGMENT:  inc[IDX_FRG] = 1'b1;
                default:       inc = '0;
            endcase
        end
    end

endmodule

// File: rtl/txstat_counter.sv
module txstat_counter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cnt,
    output logic         carry
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            carry <= 1'b0;
        end else if (wr_en) begin
            cnt   <= wr_data;
            carry <= 1'b0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
            if (cnt == TOP)
                carry <= 1'b1;
        end
    end

    // R7: wrap from all-ones lands on zero and records a carry
    assert_wrap_sets_carry_R7: assert property (@(posedge clk) disable iff (rst)
        (inc && !wr_en && cnt == TOP) |=> (cnt == '0 && carry));

    // R8: a write loads the value and clears the carry, even against an increment
    assert_write_wins_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cnt == $past(wr_data) && !carry));

    // R7: carry is sticky without a write
    assert_carry_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (carry && !wr_en) |=> carry);

endmodule

// File: rtl/txstat_overflow.sv
module txstat_overflow #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] carry,
    input  logic         mask_we,
    input  logic [N-1:0] mask_wdata,
    input  logic         clr,
    output logic [N-1:0] mask,
    output logic         ovf
);
    logic any_unmasked;

    assign any_unmasked = |(carry & ~mask);

    always_ff @(posedge clk) begin
        if (rst)
            mask <= '0;
        else if (mask_we)
            mask <= mask_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ovf <= 1'b0;
        else if (clr)
            ovf <= 1'b0;
        else if (any_unmasked)
            ovf <= 1'b1;
    end

    // R9: an unmasked carry raises the flag one edge later
    assert_unmasked_raises_R9: assert property (@(posedge clk) disable iff (rst)
        (|(carry & ~mask) && !clr) |=> ovf);

    // R10: the flag holds until a clear write
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clr) |=> ovf);

    // R10: a clear write drops the flag on that edge
    assert_clear_drops_R10: assert property (@(posedge clk) disable iff (rst)
        clr |=> !ovf);

endmodule

// File: rtl/txstat_top.sv
module txstat_top
    import txstat_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int LW = LEN_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fd_valid,
    input  logic [LW-1:0] fd_len,
    input  logic          fd_vlan,
    input  logic          fd_fcs_ok,
    input  logic          fd_fcs_chk,
    input  logic          fd_jumbo_abort,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_we,
    input  logic [CW-1:0] reg_wdata,
    output logic [CW-1:0] reg_rdata,
    output logic          ovf_irq
);
    localparam int N = NUM_CNT;

    frame_info_t           info;
    logic [N-1:0]          inc;
    logic [N-1:0]          carry;
    logic [N-1:0]          mask;
    logic [N-1:0][CW-1:0]  cnt;
    logic                  ovf;
    logic                  mask_we;
    logic                  stat_clr;

    always_comb begin
        info.len         = fd_len;
        info.vlan        = fd_vlan;
        info.fcs_ok      = fd_fcs_ok;
        info.fcs_chk     = fd_fcs_chk;
        info.jumbo_abort = fd_jumbo_abort;
    end

    txstat_classify #(.N(N)) u_classify (
        .frame_valid (fd_valid),
        .info        (info),
        .inc         (inc)
    );

    for (genvar g = 0; g < N; g++) begin : g_cnt
        logic wr_hit;
        assign wr_hit = reg_we && (reg_addr == AW'(g));
        txstat_counter #(.W(CW)) u_counter (
            .clk     (clk),
            .rst     (rst),
            .inc     (inc[g]),
            .wr_en   (wr_hit),
            .wr_data (reg_wdata),
            .cnt     (cnt[g]),
            .carry   (carry[g])
        );
    end

    assign mask_we  = reg_we && (reg_addr == A_MASK);
    assign stat_clr = reg_we && (reg_addr == A_STAT) && reg_wdata[0];

    txstat_overflow #(.N(N)) u_overflow (
        .clk        (clk),
        .rst        (rst),
        .carry      (carry),
        .mask_we    (mask_we),
        .mask_wdata (reg_wdata[N-1:0]),
        .clr        (stat_clr),
        .mask       (mask),
        .ovf        (ovf)
    );

    always_comb begin
        case (reg_addr)
            A_OVR:   reg_rdata = cnt[IDX_OVR];
            A_UND:   reg_rdata = cnt[IDX_UND];
            A_FRG:   reg_rdata = cnt[IDX_FRG];
            A_CARRY: reg_rdata = CW'(carry);
            A_MASK:  reg_rdata = CW'(mask);
            A_STAT:  reg_rdata = CW'(ovf);
            default: reg_rdata = '0;
        endcase
    end

    assign ovf_irq = ovf;

    // R5: no strobe moves more than one counter
    assert_single_class_R5: assert property (@(posedge clk) disable iff (rst)
        $countones(inc) <= 1);

endmodule

// File: tb/test_txstat_top.sv
module test_txstat_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        fd_valid;
    logic [15:0] fd_len;
    logic        fd_vlan;
    logic        fd_fcs_ok;
    logic        fd_fcs_chk;
    logic        fd_jumbo_abort;
    logic [2:0]  reg_addr;
    logic        reg_we;
    logic [11:0] reg_wdata;
    logic [11:0] reg_rdata;
    logic        ovf_irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    txstat_top i_txstat_top (
        .clk(clk), .rst(rst),
        .fd_valid(fd_valid), .fd_len(fd_len), .fd_vlan(fd_vlan),
        .fd_fcs_ok(fd_fcs_ok), .fd_fcs_chk(fd_fcs_chk),
        .fd_jumbo_abort(fd_jumbo_abort),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ovf_irq(ovf_irq)
    );

    // cls: 0 none, 1 oversize, 2 undersize, 3 fragment
    typedef struct packed {
        logic [15:0] len;
        logic        vlan;
        logic        fcs_ok;
        logic        chk;
        logic        abort;
        logic [1:0]  cls;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{16'd1519, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1},
        '{16'd1518, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0},
        '{16'd1519, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0},
        '{16'd1532, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0},
        '{16'd1533, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1},
        '{16'd1533, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0},
        '{16'd63,   1'b0, 1'b1, 1'b1, 1'b0, 2'd2},
        '{16'd63,   1'b0, 1'b0, 1'b1, 1'b0, 2'd3},
        '{16'd64,   1'b0, 1'b0, 1'b1, 1'b0, 2'd0},
        '{16'd64,   1'b0, 1'b1, 1'b1, 1'b0, 2'd0},
        '{16'd0,    1'b0, 1'b1, 1'b1, 1'b0, 2'd2},
        '{16'd9000, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2},
        '{16'd9000, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0},
        '{16'd9000, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1},
        '{16'd1,    1'b0, 1'b0, 1'b1, 1'b0, 2'd3},
        '{16'd30,   1'b0, 1'b0, 1'b0, 1'b1, 2'd2}
    };

    function automatic string req_of(logic [1:0] c);
        case (c)
            2'd1:    return "R1";
            2'd2:    return "R2/R4";
            2'd3:    return "R3";
            default: return "R5";
        endcase
    endfunction

    task automatic check(string req, logic [11:0] act, logic [11:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(logic [2:0] a, output logic [11:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(logic [2:0] a, logic [11:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        tick();
        reg_we    = 1'b0;
    endtask

    task automatic set_frame(logic [15:0] l, logic v, logic ok, logic ck, logic ab);
        fd_len = l; fd_vlan = v; fd_fcs_ok = ok; fd_fcs_chk = ck; fd_jumbo_abort = ab;
        fd_valid = 1'b1;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [11:0] v;
        logic [11:0] model [3];
        rst = 1'b1; fd_valid = 1'b0; fd_len = '0; fd_vlan = 1'b0; fd_fcs_ok = 1'b0;
        fd_fcs_chk = 1'b1; fd_jumbo_abort = 1'b0; reg_addr = '0; reg_we = 1'b0;
        reg_wdata = '0;
        model[0] = '0; model[1] = '0; model[2] = '0;
        repeat (3) tick();
        rst = 1'b0;
        @(negedge clk);

        // R6: everything zero after reset
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            check("R6 reset value", v, 12'h000);
        end
        check("R6 reset flag", {11'b0, ovf_irq}, 12'h000);

        // Table walk: R1..R5
        for (int i = 0; i < NV; i++) begin
            set_frame(VECS[i].len, VECS[i].vlan, VECS[i].fcs_ok, VECS[i].chk, VECS[i].abort);
            tick();
            fd_valid = 1'b0;
            if (VECS[i].cls != 2'd0)
                model[VECS[i].cls - 2'd1] = model[VECS[i].cls - 2'd1] + 12'd1;
            for (int c = 0; c < 3; c++) begin
                rd(3'(c), v);
                check(req_of(VECS[i].cls), v, model[c]);
            end
        end

        // R6/R8: counter write and read back
        wr(3'd0, 12'hFFF);
        rd(3'd0, v);
        check("R8 write load", v, 12'hFFF);

        // R7: wrap sets carry on the same edge; flag one edge later (R9)
        set_frame(16'd2000, 1'b0, 1'b1, 1'b1, 1'b0);
        tick();
        fd_valid = 1'b0;
        rd(3'd0, v);
        check("R7 wrap value", v, 12'h000);
        rd(3'd3, v);
        check("R7 carry bit0", v, 12'h001);
        check("R9 flag not early", {11'b0, ovf_irq}, 12'h000);
        tick();
        check("R9 flag set", {11'b0, ovf_irq}, 12'h001);
        rd(3'd5, v);
        check("R10 status reg", v, 12'h001);

        // R10: clear while carry still unmasked -> reasserts next edge
        wr(3'd5, 12'h001);
        check("R10 cleared", {11'b0, ovf_irq}, 12'h000);
        tick();
        check("R10 re-set", {11'b0, ovf_irq}, 12'h001);

        // R8: write clears carry; then clear flag stays clear
        wr(3'd0, 12'h005);
        rd(3'd3, v);
        check("R8 carry cleared", v, 12'h000);
        wr(3'd5, 12'h001);
        tick();
        tick();
        check("R10 stays clear", {11'b0, ovf_irq}, 12'h000);

        // R9: masked carry still records but raises no flag
        wr(3'd4, 12'h002);
        rd(3'd4, v);
        check("R9 mask readback", v, 12'h002);
        wr(3'd1, 12'hFFF);
        set_frame(16'd10, 1'b0, 1'b1, 1'b1, 1'b0);
        tick();
        fd_valid = 1'b0;
        rd(3'd3, v);
        check("R9 masked carry recorded", v, 12'h002);
        tick();
        tick();
        check("R9 masked no flag", {11'b0, ovf_irq}, 12'h000);
        wr(3'd4, 12'h000);
        check("R9 unmask not early", {11'b0, ovf_irq}, 12'h000);
        tick();
        check("R9 unmask raises", {11'b0, ovf_irq}, 12'h001);

        // R8: write beats a same-cycle increment
        reg_addr = 3'd2; reg_wdata = 12'h007; reg_we = 1'b1;
        set_frame(16'd5, 1'b0, 1'b0, 1'b1, 1'b0);
        tick();
        reg_we = 1'b0; fd_valid = 1'b0;
        rd(3'd2, v);
        check("R8 write priority", v, 12'h007);
        rd(3'd1, v);
        check("R5 other counter untouched", v, 12'h000);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule